// File: doc/BRIEF.md
# Shadowed Dual-Channel Configuration Register Bank

This block holds the byte-wide setup state of a two-channel converter. A plain register port carries address, write data, write strobe, read strobe and read data. Some setup registers are staged: a write lands in a shadow copy, and the datapath keeps running on the active copy. A later write of the transfer command moves every shadow value into its active copy on the same clock edge. Several settings then change together rather than one at a time.

Some registers exist once per channel. Others exist once for the whole device. A channel-index register holds one select bit per channel. For a per-channel register, that register chooses which copy a write updates and which copy a read returns. Registers shared by the whole device ignore it. The active values, together with the directly written configuration and feature bytes, leave the block as registered outputs that the datapath decodes.

Top module: `cfgbank_top`

## Requirements
- R1: After reset the registers hold these values: 0x00 = 0x18, 0x05 = 0x03, 0x08 = 0x00, 0x0D = 0x00, 0x14 = 0x01, 0x18 = 0xC0, 0x30 = 0x00 and 0x100 = 0x00. Shadow and active copies of both channels hold the same default.
- R2: A write to a staged address (0x08, 0x0D, 0x14, 0x18, 0x30) changes only its shadow copy. A read returns the new shadow value. The active outputs stay unchanged.
- R3: A write to 0xFF with data bit 0 set copies every shadow value into its active copy at that clock edge. A write to 0xFF with bit 0 clear moves nothing.
- R4: The transfer bit clears itself, so a read of 0xFF always returns 0x00.
- R5: Register 0x05 bit 0 selects Channel A and bit 1 selects Channel B. A write to a per-channel register (0x08, 0x0D, 0x30) updates the copy of each selected channel, so with both bits set it updates both.
- R6: A read of a per-channel register returns the Channel A copy when bit 0 is set, including when both bits are set. It returns the Channel B copy when only bit 1 is set.
- R7: With both select bits clear, a write to a per-channel register has no effect and a read of it returns 0x00.
- R8: The shared staged registers 0x14 and 0x18 keep one value whatever 0x05 holds. Their Channel A and Channel B active slices are always equal.
- R9: Writes to addresses outside the map have no effect. Reads from those addresses return 0x00.
- R10: Bits that a register does not implement read back as 0. The implemented-bit masks are: 0x00 0x7E, 0x05 0x03, 0x08 0xE3, 0x0D 0x3F, 0x14 0xF7, 0x18 0xC0, 0x30 0x0F and 0x100 0x0F.
- R11: Registers 0x00, 0x05 and 0x100 are not staged. `cfg_out` and `feat_out` take a written value at the edge of the write.
- R12: `rd_data` loads at the edge where `rd_en` is high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 9 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| cfg_out | output | 8 | Value of configuration register 0x00 |
| feat_out | output | 8 | Value of feature register 0x100 |
| act_a | output | 40 | Channel A active values; byte i is staged entry i (0x08, 0x0D, 0x14, 0x18, 0x30) |
| act_b | output | 40 | Channel B active values, same byte order |

## Verification
Directed sequences step the channel mask through all four codes while writing and reading per-channel registers. This separates the A-only, B-only, both and neither paths of the write and read selection. Transfer writes with bit 0 set and with bit 0 clear show whether staging and commit are kept apart, and all-ones data exposes the bit masks. A long seeded random mix of staged, direct, transfer, channel-index and out-of-map accesses is then checked after every access against a bench model. This mix catches ordering faults that the directed cases do not reach.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int NSH = 5;

    localparam int SH_ADDR [NSH] = '{'h08, 'h0D, 'h14, 'h18, 'h30};
    localparam logic [7:0] SH_DFLT [NSH] = '{8'h00, 8'h00, 8'h01, 8'hC0, 8'h00};
    localparam logic [7:0] SH_MASK [NSH] = '{8'hE3, 8'h3F, 8'hF7, 8'hC0, 8'h0F};
    localparam bit SH_LOCAL [NSH] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

    localparam int CFG_ADDR   = 'h000;
    localparam int CHIDX_ADDR = 'h005;
    localparam int XFER_ADDR  = 'h0FF;
    localparam int FEAT_ADDR  = 'h100;

    localparam logic [7:0] CFG_DFLT   = 8'h18;
    localparam logic [7:0] CFG_MASK   = 8'h7E;
    localparam logic [7:0] CHIDX_DFLT = 8'h03;
    localparam logic [7:0] CHIDX_MASK = 8'h03;
    localparam logic [7:0] FEAT_DFLT  = 8'h00;
    localparam logic [7:0] FEAT_MASK  = 8'h0F;

    typedef struct packed {
        logic [1:0][7:0] shd;
        logic [1:0][7:0] act;
    } cell_st_t;

    typedef struct packed {
        logic [7:0] val;
    } plain_st_t;

    typedef struct packed {
        logic [7:0] rd_data;
    } port_st_t;

endpackage

// File: rtl/cfgbank_plain.sv
module cfgbank_plain
    import cfgbank_pkg::*;
#(
    parameter int         ADDR_W = 9,
    parameter int         ADDR   = 0,
    parameter logic [7:0] DFLT   = 8'h00,
    parameter logic [7:0] MASK   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic              hit,
    output logic [7:0]        val
);

    plain_st_t st_d, st_q;

    assign hit = (addr == ADDR_W'(ADDR));
    assign val = st_q.val;

    always_comb begin
        st_d = st_q;
        if (wr_en && hit) begin
            st_d.val = wr_data & MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= DFLT;
        end else begin
            st_q <= st_d;
        end
    end

    // R11
    plain_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) |=> (val == ($past(wr_data) & MASK)));

endmodule

// File: rtl/cfgbank_cell.sv
module cfgbank_cell
    import cfgbank_pkg::*;
#(
    parameter int         ADDR_W   = 9,
    parameter int         ADDR     = 8,
    parameter logic [7:0] DFLT     = 8'h00,
    parameter logic [7:0] MASK     = 8'hFF,
    parameter bit         IS_LOCAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              xfer,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        ch_sel,
    output logic              hit,
    output logic [7:0]        rd_val,
    output logic [7:0]        act_a,
    output logic [7:0]        act_b
);

    cell_st_t st_d, st_q;

    assign hit   = (addr == ADDR_W'(ADDR));
    assign act_a = st_q.act[0];
    assign act_b = st_q.act[1];

    // Staging: a write only reaches the shadow copies
    always_comb begin
        st_d = st_q;
        if (wr_en && hit) begin
            for (int c = 0; c < 2; c++) begin
                if (!IS_LOCAL || ch_sel[c]) begin
                    st_d.shd[c] = wr_data & MASK;
                end
            end
        end
        if (xfer) begin
            st_d.act = st_q.shd;
        end
    end

    // Read selection: Channel A wins when both are selected
    always_comb begin
        if (!IS_LOCAL) begin
            rd_val = st_q.shd[0];
        end else if (ch_sel[0]) begin
            rd_val = st_q.shd[0];
        end else if (ch_sel[1]) begin
            rd_val = st_q.shd[1];
        end else begin
            rd_val = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shd <= {DFLT, DFLT};
            st_q.act <= {DFLT, DFLT};
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> ($stable(act_a) && $stable(act_b)));

    // R3
    xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> ((act_a == $past(st_q.shd[0])) && (act_b == $past(st_q.shd[1]))));

    generate
        if (IS_LOCAL) begin : g_local_chk
            // R7
            no_sel_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && hit && (ch_sel == 2'b00)) |=> $stable(st_q.shd));
        end else begin : g_global_chk
            // R8
            shared_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
                act_a == act_b);
        end
    endgenerate

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
    import cfgbank_pkg::*;
#(
    parameter int ADDR_W = 9,
    localparam int ACT_W = NSH * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic [7:0]        cfg_out,
    output logic [7:0]        feat_out,
    output logic [ACT_W-1:0]  act_a,
    output logic [ACT_W-1:0]  act_b
);

    port_st_t   st_d, st_q;
    logic       xfer;
    logic       xfer_hit;
    logic       cfg_hit, chidx_hit, feat_hit;
    logic [7:0] chidx_val;
    logic [1:0] ch_sel;
    logic [NSH-1:0] cell_hit;
    logic [7:0]     cell_rd [NSH];
    logic [7:0]     rd_mux;
    logic           known;

    assign xfer_hit = (addr == ADDR_W'(XFER_ADDR));
    assign xfer     = wr_en && xfer_hit && wr_data[0];
    assign ch_sel   = chidx_val[1:0];

    cfgbank_plain #(
        .ADDR_W(ADDR_W), .ADDR(CFG_ADDR), .DFLT(CFG_DFLT), .MASK(CFG_MASK)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .hit(cfg_hit), .val(cfg_out)
    );

    cfgbank_plain #(
        .ADDR_W(ADDR_W), .ADDR(CHIDX_ADDR), .DFLT(CHIDX_DFLT), .MASK(CHIDX_MASK)
    ) i_chidx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .hit(chidx_hit), .val(chidx_val)
    );

    cfgbank_plain #(
        .ADDR_W(ADDR_W), .ADDR(FEAT_ADDR), .DFLT(FEAT_DFLT), .MASK(FEAT_MASK)
    ) i_feat (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .hit(feat_hit), .val(feat_out)
    );

    generate
        for (genvar g = 0; g < NSH; g++) begin : g_cell
            cfgbank_cell #(
                .ADDR_W(ADDR_W), .ADDR(SH_ADDR[g]), .DFLT(SH_DFLT[g]),
                .MASK(SH_MASK[g]), .IS_LOCAL(SH_LOCAL[g])
            ) i_cell (
                .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .xfer(xfer),
                .addr(addr), .wr_data(wr_data), .ch_sel(ch_sel),
                .hit(cell_hit[g]), .rd_val(cell_rd[g]),
                .act_a(act_a[g*8 +: 8]), .act_b(act_b[g*8 +: 8])
            );
        end
    endgenerate

    // Read multiplexer; the transfer location always reads as zero
    always_comb begin
        rd_mux = 8'h00;
        known  = cfg_hit || chidx_hit || feat_hit || xfer_hit;
        if (cfg_hit)   rd_mux = cfg_out;
        if (chidx_hit) rd_mux = chidx_val;
        if (feat_hit)  rd_mux = feat_out;
        for (int i = 0; i < NSH; i++) begin
            if (cell_hit[i]) begin
                rd_mux = cell_rd[i];
                known  = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rd_data = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rd_data <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd_data;

    // R4
    xfer_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && xfer_hit) |=> (rd_data == 8'h00));

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !known) |=> (rd_data == 8'h00));

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R7
    no_sel_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (ch_sel == 2'b00) && (cell_hit[0] || cell_hit[1] || cell_hit[4]))
        |=> (rd_data == 8'h00));

endmodule

// File: tb/test_cfgbank_top.sv
module test_cfgbank_top;

    localparam int NS = 5;
    localparam int SADDR [NS] = '{'h08, 'h0D, 'h14, 'h18, 'h30};
    localparam logic [7:0] SDEF [NS] = '{8'h00, 8'h00, 8'h01, 8'hC0, 8'h00};
    localparam logic [7:0] SMSK [NS] = '{8'hE3, 8'h3F, 8'hF7, 8'hC0, 8'h0F};
    localparam bit SLOC [NS] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data, cfg_out, feat_out;
    logic [39:0] act_a, act_b;

    int checks = 0;
    int fails = 0;

    logic [7:0] m_shd [NS][2];
    logic [7:0] m_act [NS][2];
    logic [7:0] m_cfg, m_chs, m_feat;

    always #10 clk = ~clk;

    cfgbank_top i_cfgbank_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .cfg_out(cfg_out),
        .feat_out(feat_out), .act_a(act_a), .act_b(act_b)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int find_idx(input int a);
        for (int i = 0; i < NS; i++) if (SADDR[i] == a) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_rd(input int a);
        int i;
        i = find_idx(a);
        if (i >= 0) begin
            if (!SLOC[i]) return m_shd[i][0];
            if (m_chs[0]) return m_shd[i][0];
            if (m_chs[1]) return m_shd[i][1];
            return 8'h00;
        end
        if (a == 'h000) return m_cfg;
        if (a == 'h005) return m_chs;
        if (a == 'h100) return m_feat;
        return 8'h00;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            for (int c = 0; c < 2; c++) begin
                m_shd[i][c] = SDEF[i];
                m_act[i][c] = SDEF[i];
            end
        end
        m_cfg = 8'h18; m_chs = 8'h03; m_feat = 8'h00;
    endtask

    task automatic model_wr(input int a, input logic [7:0] d);
        int i;
        i = find_idx(a);
        if (i >= 0) begin
            for (int c = 0; c < 2; c++)
                if (!SLOC[i] || m_chs[c]) m_shd[i][c] = d & SMSK[i];
        end else if (a == 'h000) m_cfg = d & 8'h7E;
        else if (a == 'h005) m_chs = d & 8'h03;
        else if (a == 'h100) m_feat = d & 8'h0F;
        else if (a == 'h0FF && d[0]) begin
            for (int k = 0; k < NS; k++) begin
                m_act[k][0] = m_shd[k][0];
                m_act[k][1] = m_shd[k][1];
            end
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        addr = a[8:0]; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        addr = a[8:0]; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rd_data, exp_rd(a));
    endtask

    task automatic check_outs(input string tag);
        for (int i = 0; i < NS; i++) begin
            check(tag, act_a[i*8 +: 8], m_act[i][0]);
            check(tag, act_b[i*8 +: 8], m_act[i][1]);
        end
        check(tag, cfg_out, m_cfg);
        check(tag, feat_out, m_feat);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] held;
        int seed;
        int pick;
        int a;
        logic [7:0] d;
        seed = $urandom(32'h1C0F_5EED);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values on outputs and through reads
        check_outs("R1");
        foreach (SADDR[i]) rd(SADDR[i], "R1");
        rd('h000, "R1"); rd('h005, "R1"); rd('h100, "R1");

        // R10 / R2: all-ones into a staged register reads masked, active unchanged
        wr('h08, 8'hFF);
        rd('h08, "R10");
        check_outs("R2");
        wr('h14, 8'hFF);
        rd('h14, "R10");

        // R3: bit 0 clear moves nothing, bit 0 set commits everything
        wr('hFF, 8'hFE);
        check_outs("R3");
        wr('hFF, 8'h01);
        check_outs("R3");
        check("R3", act_a[7:0], 8'hE3);
        // R4
        rd('hFF, "R4");

        // R5 / R6: B only, then both
        wr('h05, 8'h02);
        wr('h0D, 8'h15);
        rd('h0D, "R6");
        wr('h05, 8'h01);
        rd('h0D, "R6");
        wr('h05, 8'h03);
        rd('h0D, "R6");
        wr('h30, 8'hAA);
        wr('hFF, 8'h01);
        check_outs("R5");
        check("R5", act_b[39:32], 8'h0A);

        // R7: neither channel selected
        wr('h05, 8'h00);
        wr('h08, 8'h00);
        rd('h08, "R7");
        wr('h05, 8'h03);
        rd('h08, "R7");

        // R8: shared register ignores the mask
        wr('h05, 8'h01);
        wr('h18, 8'h40);
        wr('h05, 8'h02);
        rd('h18, "R8");
        wr('hFF, 8'h01);
        check("R8", act_b[31:24], act_a[31:24]);
        check_outs("R8");

        // R9: unmapped addresses
        wr('h002, 8'hFF);
        wr('h101, 8'hFF);
        wr('h1FF, 8'h01);
        rd('h002, "R9"); rd('h101, "R9"); rd('h031, "R9");
        check_outs("R9");

        // R11: direct registers take effect at the write edge
        wr('h000, 8'hFF);
        check("R11", cfg_out, 8'h7E);
        wr('h100, 8'hA5);
        check("R11", feat_out, 8'h05);

        // R12: read data holds while rd_en is low
        rd('h000, "R12");
        held = rd_data;
        @(negedge clk);
        addr = 9'h100;
        @(negedge clk);
        check("R12", rd_data, held);

        // Random mix, R2 R3 R5 R6 checked against the model
        for (int n = 0; n < 600; n++) begin
            pick = $urandom_range(0, 9);
            d = 8'($urandom);
            case (pick)
                0: a = 'h005;
                1: a = 'h0FF;
                2: a = 'h000;
                3: a = 'h100;
                4: a = $urandom_range(0, 511);
                default: a = SADDR[$urandom_range(0, NS-1)];
            endcase
            if ($urandom_range(0, 2) == 0) rd(a, "R6");
            else begin
                wr(a, d);
                check_outs("R2");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule